// File: doc/BRIEF.md
# Self-Synchronising PRBS Word Checker

This block compares each received parallel data word against one of four pseudo-random binary sequences and reports mismatches. A 3-bit select input picks the sequence; the inactive and unused select codes turn checking off. The checker has no separate lock phase. It keeps the last valid word it received and uses it to work out the word that should follow. Because of this, a single corrupted bit is reported in the word that carries it. It is also reported in the next word when the corrupted bit feeds that next word's prediction.

Two results come out of the block. The first is a per-word error flag that describes only the most recent comparison. The second is a saturating count of the words that failed. The count can be cleared on its own without a reset. The block is meant to sit behind a deserialiser in a link test path. Software or test logic reads the count after a soak, or watches the flag to find error bursts.

Top module: `prbs_pattern_checker`

## Requirements
- R1: Select 3'b001 checks PRBS-7 (x^7+x^6+1), 3'b010 PRBS-15 (x^15+x^14+1), 3'b011 PRBS-23 (x^23+x^18+1) and 3'b100 PRBS-31 (x^31+x^28+1). Bit 0 of a word is the earliest sequence bit, and bit n of the sequence equals bit n-LEN XOR bit n-TAP. A clean contiguous stream raises no error flag.
- R2: Select 3'b000 and the codes 3'b101 to 3'b111 perform no checking. The flag stays low and the counter does not move, even for corrupted data.
- R3: The next word is predicted from the last valid received word. One inverted bit at position p of word k flags word k. It also flags word k+1 when p >= 32-LEN. The words after that are clean.
- R4: `err_flag` is registered. It is high in the cycle after a valid word that mismatched and low in every other cycle, including cycles without a valid word. It is never sticky.
- R5: `err_cnt` rises by one in the same cycle that `err_flag` goes high and otherwise holds. It saturates at all-ones.
- R6: When `cnt_clr` is high at a clock edge, `err_cnt` reads zero after that edge. The clear takes priority over an increment in the same cycle, while `err_flag` still reports that cycle's word.
- R7: The first valid word after reset, and the first valid word after `pat_sel` changes, only seeds the predictor and never raises an error. Cycles without a valid word keep the stored seed.
- R8: After a synchronous reset, `err_flag` is 0 and `err_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | `rx_data` holds a word this cycle |
| rx_data | input | DATA_W | Received word, bit 0 earliest |
| pat_sel | input | 3 | Sequence select |
| cnt_clr | input | 1 | Clears the error counter |
| err_flag | output | 1 | Last valid word mismatched |
| err_cnt | output | CNT_W | Saturating mismatch count |

## Verification
A word presented at one clock edge has its result on both `err_flag` and `err_cnt` exactly one edge later, and `cnt_clr` also acts after one edge. The bench drives inputs on the falling edge and reads each result at the following falling edge, so every check samples one register stage after its stimulus. The bench builds its streams with its own serial sequence generator. It predicts burst lengths from the rule stated in R3, not from the design's structure.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

   localparam int NUM_PAT = 4;
   localparam int SEL_W   = 3;
   localparam int IDX_W   = $clog2(NUM_PAT);

   // sequence degree for pattern index g (select code g+1)
   function automatic int pat_len(input int g);
      case (g)
         0:       return 7;
         1:       return 15;
         2:       return 23;
         default: return 31;
      endcase
   endfunction

   // second feedback tap for pattern index g
   function automatic int pat_tap(input int g);
      case (g)
         0:       return 6;
         1:       return 14;
         2:       return 18;
         default: return 28;
      endcase
   endfunction

endpackage

// File: rtl/prbs_word_predict.sv
module prbs_word_predict #(
   parameter int W   = 32,
   parameter int LEN = 7,
   parameter int TAP = 6
) (
   input  logic [W-1:0] prev_word,
   output logic [W-1:0] next_word
);

   generate
      if (LEN > W || TAP < 1 || TAP >= LEN) begin : g_bad_cfg
         $error("prbs_word_predict: LEN must fit in W and 1 <= TAP < LEN");
      end
   endgenerate

   // extend the previous word by W bits using the recurrence
   function automatic logic [W-1:0] extend(input logic [W-1:0] p);
      logic [2*W-1:0] e;
      e = '0;
      e[W-1:0] = p;
      for (int j = 0; j < W; j++) begin
         e[W+j] = e[W+j-LEN] ^ e[W+j-TAP];
      end
      return e[2*W-1:W];
   endfunction

   assign next_word = extend(prev_word);

endmodule

// File: rtl/prbs_err_counter.sv
module prbs_err_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("prbs_err_counter: CNT_W must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         cnt <= '0;
      end else if (inc && cnt != CNT_MAX) begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/prbs_pattern_checker.sv
module prbs_pattern_checker
   import prbs_chk_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic [2:0]        pat_sel,
   input  logic              cnt_clr,
   output logic              err_flag,
   output logic [CNT_W-1:0]  err_cnt
);

   generate
      if (DATA_W < 31) begin : g_bad_width
         $error("prbs_pattern_checker: DATA_W must hold the longest seed");
      end
   endgenerate

   logic [DATA_W-1:0] seed_q;
   logic [SEL_W-1:0]  sel_q;
   logic              seeded_q;
   logic [DATA_W-1:0] pred [NUM_PAT];
   logic [IDX_W-1:0]  pat_idx;
   logic              pat_on;
   logic              mismatch_c;

   genvar g;
   generate
      for (g = 0; g < NUM_PAT; g++) begin : g_pred
         prbs_word_predict #(
            .W   (DATA_W),
            .LEN (pat_len(g)),
            .TAP (pat_tap(g))
         ) u_pred (
            .prev_word (seed_q),
            .next_word (pred[g])
         );
      end
   endgenerate

   assign pat_on  = (pat_sel != '0) && (int'(pat_sel) <= NUM_PAT);
   assign pat_idx = IDX_W'(pat_sel - 3'd1);

   assign mismatch_c = rx_valid && pat_on && seeded_q &&
                       (pat_sel == sel_q) && (rx_data != pred[pat_idx]);

   always_ff @(posedge clk) begin
      if (rst) begin
         seed_q   <= '0;
         sel_q    <= '0;
         seeded_q <= 1'b0;
         err_flag <= 1'b0;
      end else begin
         err_flag <= mismatch_c;
         if (rx_valid) begin
            seed_q   <= rx_data;
            sel_q    <= pat_sel;
            seeded_q <= 1'b1;
         end else if (pat_sel != sel_q) begin
            seeded_q <= 1'b0;
         end
      end
   end

   prbs_err_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk (clk),
      .rst (rst),
      .clr (cnt_clr),
      .inc (mismatch_c),
      .cnt (err_cnt)
   );

endmodule

// File: rtl/prbs_checker_sva.sv
module prbs_checker_sva #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             rx_valid,
   input logic [2:0]       pat_sel,
   input logic             cnt_clr,
   input logic             err_flag,
   input logic [CNT_W-1:0] err_cnt
);

   AST_FLAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
      err_flag |-> $past(rx_valid)); // R4

   AST_QUIET_SELECT: assert property (@(posedge clk) disable iff (rst)
      err_flag |-> ($past(pat_sel) >= 3'd1 && $past(pat_sel) <= 3'd4)); // R2

   AST_RESEED_NO_ERR: assert property (@(posedge clk) disable iff (rst)
      ($past(rx_valid) && $past(pat_sel) != $past(pat_sel, 2)) |-> !err_flag); // R7

   AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
      cnt_clr |=> (err_cnt == '0)); // R6

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
      (err_flag && !$past(cnt_clr) && $past(err_cnt) != '1)
         |-> (err_cnt == CNT_W'($past(err_cnt) + 1'b1))); // R5

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!err_flag && !$past(cnt_clr)) |-> $stable(err_cnt)); // R5

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      ($past(err_cnt) == '1 && !$past(cnt_clr)) |-> (err_cnt == '1)); // R5

endmodule

bind prbs_pattern_checker prbs_checker_sva #(.CNT_W(CNT_W)) u_sva (
   .clk      (clk),
   .rst      (rst),
   .rx_valid (rx_valid),
   .pat_sel  (pat_sel),
   .cnt_clr  (cnt_clr),
   .err_flag (err_flag),
   .err_cnt  (err_cnt)
);

// File: tb/sim_prbs_pattern_checker.sv
module sim_prbs_pattern_checker;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int CW = 16;

   typedef struct packed {
      logic [2:0]  sel;
      logic [7:0]  nwords;
      logic [7:0]  flip_at;   // 8'hFF = no corruption
      logic [4:0]  flip_bit;
      logic [31:0] seed;
   } vec_t;

   localparam int NVEC = 13;
   localparam vec_t VECS [NVEC] = '{
      '{3'd1, 8'd20, 8'hFF, 5'd0,  32'h1234_5678},
      '{3'd2, 8'd20, 8'hFF, 5'd0,  32'h0BAD_F00D},
      '{3'd3, 8'd20, 8'hFF, 5'd0,  32'hCAFE_0001},
      '{3'd4, 8'd20, 8'hFF, 5'd0,  32'h8000_0003},
      '{3'd1, 8'd12, 8'd5,  5'd31, 32'h5A5A_1111},
      '{3'd1, 8'd12, 8'd5,  5'd0,  32'h5A5A_2222},
      '{3'd2, 8'd12, 8'd4,  5'd20, 32'h7777_0101},
      '{3'd3, 8'd12, 8'd3,  5'd5,  32'h1357_9BDF},
      '{3'd4, 8'd12, 8'd6,  5'd1,  32'h0F0F_3C3C},
      '{3'd4, 8'd12, 8'd6,  5'd0,  32'h2468_ACE0},
      '{3'd0, 8'd10, 8'd3,  5'd7,  32'hDEAD_BEEF},
      '{3'd5, 8'd10, 8'd2,  5'd9,  32'h3333_5555},
      '{3'd7, 8'd10, 8'd2,  5'd30, 32'h9999_AAAA}
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          rx_valid = 1'b0;
   logic [DW-1:0] rx_data = '0;
   logic [2:0]    pat_sel = 3'd0;
   logic          cnt_clr = 1'b0;
   logic          err_flag;
   logic [CW-1:0] err_cnt;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prbs_pattern_checker #(.DATA_W(DW), .CNT_W(CW)) u0 (
      .clk      (clk),
      .rst      (rst),
      .rx_valid (rx_valid),
      .rx_data  (rx_data),
      .pat_sel  (pat_sel),
      .cnt_clr  (cnt_clr),
      .err_flag (err_flag),
      .err_cnt  (err_cnt)
   );

   // sequence degree and tap per select code (from R1)
   function automatic int len_of(input logic [2:0] s);
      case (s)
         3'd2: return 15;
         3'd3: return 23;
         3'd4: return 31;
         default: return 7;
      endcase
   endfunction

   function automatic int tap_of(input logic [2:0] s);
      case (s)
         3'd2: return 14;
         3'd3: return 18;
         3'd4: return 28;
         default: return 6;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // serial generator: h[k-1] holds the bit k positions back
   task automatic gen_word(input int n, input int m, inout logic [63:0] h,
                           output logic [31:0] w);
      for (int j = 0; j < 32; j++) begin
         logic b;
         b = h[n-1] ^ h[m-1];
         h = {h[62:0], b};
         w[j] = b;
      end
   endtask

   task automatic idle_clear();
      @(negedge clk);
      rx_valid = 1'b0;
      pat_sel  = 3'd0;
      cnt_clr  = 1'b1;
      @(negedge clk);
      cnt_clr  = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [63:0] h;
      logic [31:0] w;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R8 flag after reset", 32'(err_flag), 32'd0);
      chk("R8 count after reset", 32'(err_cnt), 32'd0);

      // table walk: R1 clean streams, R3 bursts, R2 quiet selects, R4/R5 per word
      for (int v = 0; v < NVEC; v++) begin
         int n, m, fa, exp_cnt;
         bit act_sel, second;
         idle_clear();
         chk("R6 count cleared", 32'(err_cnt), 32'd0);
         n = len_of(VECS[v].sel);
         m = tap_of(VECS[v].sel);
         act_sel = (VECS[v].sel >= 3'd1 && VECS[v].sel <= 3'd4);
         fa = (VECS[v].flip_at == 8'hFF) ? -10 : int'(VECS[v].flip_at);
         second = (int'(VECS[v].flip_bit) >= 32 - n);   // R3 burst rule
         exp_cnt = 0;
         h = {VECS[v].seed, VECS[v].seed};
         for (int i = 0; i < int'(VECS[v].nwords); i++) begin
            bit ef;
            gen_word(n, m, h, w);
            if (i == fa) w[VECS[v].flip_bit] = ~w[VECS[v].flip_bit];
            rx_valid = 1'b1;
            pat_sel  = VECS[v].sel;
            rx_data  = w;
            @(negedge clk);
            ef = act_sel && ((i == fa) || (i == fa + 1 && second));
            if (ef) exp_cnt++;
            if (act_sel) chk("R3 R4 R1 flag per word", 32'(err_flag), 32'(ef));
            else         chk("R2 flag quiet", 32'(err_flag), 32'd0);
         end
         rx_valid = 1'b0;
         if (act_sel) chk("R5 R3 count per vector", 32'(err_cnt), 32'(exp_cnt));
         else         chk("R2 count unchanged", 32'(err_cnt), 32'd0);
         @(negedge clk);
         chk("R4 flag low without valid", 32'(err_flag), 32'd0);
      end

      // R7 and R4: gap keeps seed, select change reseeds
      idle_clear();
      h = {2{32'h4242_1717}};
      for (int i = 0; i < 6; i++) begin
         gen_word(7, 6, h, w);
         rx_valid = 1'b1; pat_sel = 3'd1; rx_data = w;
         @(negedge clk);
         chk("R7 first word seeds, stream clean", 32'(err_flag), 32'd0);
      end
      rx_valid = 1'b0;
      repeat (3) begin
         @(negedge clk);
         chk("R4 flag low in gap", 32'(err_flag), 32'd0);
      end
      gen_word(7, 6, h, w);
      rx_valid = 1'b1; rx_data = w;
      @(negedge clk);
      chk("R7 seed kept across gap", 32'(err_flag), 32'd0);
      h = {2{32'h6C6C_0F0F}};
      for (int i = 0; i < 5; i++) begin
         gen_word(15, 14, h, w);
         rx_valid = 1'b1; pat_sel = 3'd2; rx_data = w;
         @(negedge clk);
         chk("R7 reseed after select change", 32'(err_flag), 32'd0);
      end
      chk("R7 count after reseed", 32'(err_cnt), 32'd0);

      // R6 clear wins; R5 saturation with constant all-ones under PRBS-7
      rx_valid = 1'b1; pat_sel = 3'd1; rx_data = '1;
      @(negedge clk);
      chk("R7 new select seeds", 32'(err_flag), 32'd0);
      cnt_clr = 1'b1;
      @(negedge clk);
      chk("R6 flag still reports", 32'(err_flag), 32'd1);
      chk("R6 clear beats increment", 32'(err_cnt), 32'd0);
      cnt_clr = 1'b0;
      @(negedge clk);
      chk("R5 first increment", 32'(err_cnt), 32'd1);
      repeat (65540) @(negedge clk);
      chk("R5 saturated", 32'(err_cnt), 32'hFFFF);
      chk("R4 flag non-sticky stream still failing", 32'(err_flag), 32'd1);
      rx_valid = 1'b0;
      @(negedge clk);
      chk("R5 held at max", 32'(err_cnt), 32'hFFFF);
      chk("R4 flag drops", 32'(err_flag), 32'd0);
      cnt_clr = 1'b1;
      @(negedge clk);
      cnt_clr = 1'b0;
      chk("R6 clear from max", 32'(err_cnt), 32'd0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule